// File: doc/BRIEF.md
# Serial Converter Front End with Pipelined Channel Select

This block is the digital side of an 8-bit, multichannel, serially controlled converter. A host lowers an active-low select line and sends eight serial clocks. On the rising edges of the first four clocks it shifts in a 4-bit channel address, MSB first. On the falling edges of all eight clocks the block shifts out, MSB first, the result of the conversion before this one. So each transfer both requests the next conversion and collects the last one. The last four clocks mark the sampling interval. After the eighth clock the block starts a conversion, disables its serial output and ignores the serial clock until the conversion completes. It drops an end-of-conversion flag while the conversion runs and raises it again when the new result is ready.

The analog converter sits outside the block and is reached through a parallel handshake. The block sends a start pulse together with a channel number, and the converter answers with a done pulse and an 8-bit result. Addresses above the last input channel select a built-in midpoint test. The test is answered inside the block with the mid-scale code, and no external conversion is started. The select line and the serial clock are synchronized into the converter clock domain. The select line must stay low for a minimum number of clocks before the block treats its fall as an interface reset. A reset that arrives during a conversion aborts that conversion.

Top module: `adcSerialSlave`

## Requirements
- R1: While the synchronized select input is high, `sdoOe` is low. `sdoOe` is high only after a qualified select fall and only while the block is shifting, that is, not converting.
- R2: A select low that lasts `CS_VALID` (default 3) synchronized clocks or more is an interface reset: the bit count returns to zero and the output reloads from the stored result. A low pulse of one clock is ignored: no reset and no abort.
- R3: An interface reset while a conversion runs pulses `convAbort` for one clock and sets `eoc` high. The stored result keeps its old value and a new transfer can start.
- R4: The stored 8-bit result appears on `sdo` MSB first. The MSB is present before the first serial clock falls, and each falling edge advances one bit.
- R5: The channel address is taken MSB first from `din` on rising clocks 1 to 4. `din` on rising clocks 5 to 8 is ignored.
- R6: On the eighth falling serial clock, `eoc` goes low. For channel codes 0x0 to 0xA, `convStart` pulses for one clock in the same cycle, with the code on `convChan`.
- R7: After the eighth falling clock, `sdoOe` is low even if select stays low. Serial clocks during the conversion neither advance the bit count nor shift data.
- R8: A `convDone` pulse during an external conversion stores `convResult`, raises `eoc` and loads the new result for the next transfer.
- R9: Codes 0xB to 0xF select the self-test. No `convStart` is issued, and after `TEST_LAT` clocks the stored result becomes 0x80 and `eoc` rises.
- R10: `convSample` is high while shifting with 4 to 7 falling edges counted, that is, during serial clocks 5 to 8.
- R11: After `rstN` the stored result is 0x00, `eoc` is high, and `sdoOe`, `convStart` and `convAbort` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Converter clock |
| rstN | input | 1 | Asynchronous active-low reset |
| csN | input | 1 | Active-low select, asynchronous |
| sclk | input | 1 | Serial clock, asynchronous, slower than clk/4 |
| din | input | 1 | Serial address input |
| convResult | input | DATA_W | Result from the external converter |
| convDone | input | 1 | One-clock pulse: convResult is valid |
| sdo | output | 1 | Serial result bit |
| sdoOe | output | 1 | Enable for the three-state pad driving sdo |
| eoc | output | 1 | End of conversion, low while converting |
| convStart | output | 1 | One-clock pulse that starts a conversion |
| convAbort | output | 1 | One-clock pulse that cancels a running conversion |
| convChan | output | ADDR_W | Channel number for the converter, test codes folded to 0xB |
| convSample | output | 1 | Sampling interval, serial clocks 5 to 8 |

## Verification
The in-line assertions check on every cycle the rules that hold regardless of stimulus. These are: output disable after select rises, the start pulse coinciding with the fall of `eoc`, a frozen bit count while converting, and the stored result changing only on a completion. They also check the mid-scale value after a self-test and the abort pulse leaving `eoc` high. Only the bench scenarios can show the end-to-end results of a sequence of transfers. These are the one-transfer lag between address and result, the ignored trailing address bits, glitch rejection and abort, and that extra clocks during a lockout leave the next frame aligned.

// File: rtl/adcSerialPkg.sv
package adcSerialPkg;

  typedef enum logic [1:0] {
    ST_SHIFT     = 2'd0,
    ST_CONV_EXT  = 2'd1,
    ST_CONV_TEST = 2'd2
  } convState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic reload;      // reload output shifter from stored result
    logic shiftOut;    // advance output shifter one bit
    logic shiftAddr;   // take one address bit
    logic clrAddr;     // clear address register
    logic takeResult;  // store external converter result
    logic takeTest;    // store self-test value
  } dpCtrl_t;

endpackage

// File: rtl/adcSyncChain.sv
module adcSyncChain #(
  parameter int   STAGES    = 2,
  parameter logic RESET_VAL = 1'b0
) (
  input  logic clk,
  input  logic rstN,
  input  logic asyncIn,
  output logic syncOut
);
  logic [STAGES-1:0] stage;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) stage <= RESET_VAL;
        else       stage <= asyncIn;
      end
    end else begin : g_multi
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) stage <= {STAGES{RESET_VAL}};
        else       stage <= {stage[STAGES-2:0], asyncIn};
      end
    end
  endgenerate

  assign syncOut = stage[STAGES-1];
endmodule

// File: rtl/adcSerialCtrl.sv
module adcSerialCtrl
  import adcSerialPkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int ADDR_W   = 4,
  parameter int CS_VALID = 3,
  parameter int TEST_LAT = 4
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    sclkS,
  input  logic    csNS,
  input  logic    isTestChan,
  input  logic    convDone,
  output dpCtrl_t ctl,
  output logic    convStart,
  output logic    convAbort,
  output logic    eoc,
  output logic    sdoOe,
  output logic    convSample
);
  localparam int FRAME  = DATA_W;
  localparam int BIT_W  = $clog2(FRAME + 1);
  localparam int LOW_W  = $clog2(CS_VALID + 1);
  localparam int TCNT_W = $clog2(TEST_LAT + 1);

  convState_e        state;
  logic              sclkQ;
  logic              sclkRise, sclkFall;
  logic [LOW_W-1:0]  lowCnt;
  logic              csActive;
  logic              ifaceReset;
  logic [BIT_W-1:0]  bitCnt;
  logic [TCNT_W-1:0] testCnt;
  logic              testDone;
  logic              shiftEn;
  logic              lastFall;

  // serial clock edge detection in converter clock domain
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) sclkQ <= 1'b0;
    else       sclkQ <= sclkS;
  end
  assign sclkRise = sclkS & ~sclkQ;
  assign sclkFall = ~sclkS & sclkQ;

  // select qualification by duration
  assign ifaceReset = !csNS && (lowCnt == LOW_W'(CS_VALID - 1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lowCnt   <= '0;
      csActive <= 1'b0;
    end else if (csNS) begin
      lowCnt   <= '0;
      csActive <= 1'b0;
    end else begin
      if (lowCnt != LOW_W'(CS_VALID)) lowCnt <= lowCnt + 1'b1;
      if (ifaceReset) csActive <= 1'b1;
    end
  end

  assign shiftEn  = csActive && (state == ST_SHIFT) && !ifaceReset;
  assign lastFall = shiftEn && sclkFall && (bitCnt == BIT_W'(FRAME - 1));
  assign testDone = (state == ST_CONV_TEST) && (testCnt == TCNT_W'(TEST_LAT - 1));

  // frame and conversion sequencing
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_SHIFT;
      bitCnt    <= '0;
      testCnt   <= '0;
      eoc       <= 1'b1;
      convStart <= 1'b0;
      convAbort <= 1'b0;
    end else begin
      convStart <= 1'b0;
      convAbort <= 1'b0;
      if (ifaceReset) begin
        if (state != ST_SHIFT) convAbort <= 1'b1;
        state  <= ST_SHIFT;
        bitCnt <= '0;
        eoc    <= 1'b1;
      end else begin
        unique case (state)
          ST_SHIFT: begin
            if (lastFall) begin
              bitCnt  <= BIT_W'(FRAME);
              eoc     <= 1'b0;
              testCnt <= '0;
              if (isTestChan) begin
                state <= ST_CONV_TEST;
              end else begin
                state     <= ST_CONV_EXT;
                convStart <= 1'b1;
              end
            end else if (shiftEn && sclkFall) begin
              bitCnt <= bitCnt + 1'b1;
            end
          end
          ST_CONV_EXT: begin
            if (convDone) begin
              state  <= ST_SHIFT;
              bitCnt <= '0;
              eoc    <= 1'b1;
            end
          end
          ST_CONV_TEST: begin
            if (testDone) begin
              state  <= ST_SHIFT;
              bitCnt <= '0;
              eoc    <= 1'b1;
            end else begin
              testCnt <= testCnt + 1'b1;
            end
          end
          default: state <= ST_SHIFT;
        endcase
      end
    end
  end

  // strobes to datapath
  always_comb begin
    ctl            = '0;
    ctl.reload     = ifaceReset;
    ctl.clrAddr    = ifaceReset;
    ctl.shiftOut   = shiftEn && sclkFall;
    ctl.shiftAddr  = shiftEn && sclkRise && (bitCnt < BIT_W'(ADDR_W));
    ctl.takeResult = !ifaceReset && (state == ST_CONV_EXT) && convDone;
    ctl.takeTest   = !ifaceReset && testDone;
  end

  assign sdoOe      = csActive && (state == ST_SHIFT);
  assign convSample = csActive && (state == ST_SHIFT) && (bitCnt >= BIT_W'(ADDR_W));

  // output released one cycle after select rises
  assert_oe_off_R1: assert property (@(posedge clk) disable iff (!rstN)
    csNS |=> !sdoOe);

  // start pulse coincides with the fall of eoc
  assert_start_eoc_R6: assert property (@(posedge clk) disable iff (!rstN)
    convStart |-> $fell(eoc));

  // bit count frozen during conversion
  assert_lockout_R7: assert property (@(posedge clk) disable iff (!rstN)
    (state != ST_SHIFT) |-> (bitCnt == BIT_W'(FRAME)));

  // eoc only rises when leaving a conversion
  assert_eoc_rise_R8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(eoc) |-> ($past(state) != ST_SHIFT));

  // abort leaves the block ready
  assert_abort_R3: assert property (@(posedge clk) disable iff (!rstN)
    convAbort |-> (eoc && !convStart));

endmodule

// File: rtl/adcSerialDatapath.sv
module adcSerialDatapath
  import adcSerialPkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int ADDR_W     = 4,
  parameter int NUM_INPUTS = 11
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtrl_t           ctl,
  input  logic              dinS,
  input  logic [DATA_W-1:0] convResult,
  output logic              sdo,
  output logic              isTestChan,
  output logic [ADDR_W-1:0] convChan
);
  localparam logic [DATA_W-1:0] TEST_VALUE = DATA_W'(1) << (DATA_W - 1);
  localparam logic [ADDR_W-1:0] TEST_CODE  = ADDR_W'(NUM_INPUTS);

  logic [ADDR_W-1:0] addrShift;
  logic [DATA_W-1:0] resultReg;
  logic [DATA_W-1:0] outShift;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              addrShift <= '0;
    else if (ctl.clrAddr)   addrShift <= '0;
    else if (ctl.shiftAddr) addrShift <= {addrShift[ADDR_W-2:0], dinS};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               resultReg <= '0;
    else if (ctl.takeResult) resultReg <= convResult;
    else if (ctl.takeTest)   resultReg <= TEST_VALUE;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               outShift <= '0;
    else if (ctl.takeResult) outShift <= convResult;
    else if (ctl.takeTest)   outShift <= TEST_VALUE;
    else if (ctl.reload)     outShift <= resultReg;
    else if (ctl.shiftOut)   outShift <= {outShift[DATA_W-2:0], 1'b0};
  end

  // channel codes at or above the input count fold onto the test code
  assign isTestChan = (addrShift >= TEST_CODE);
  assign convChan   = isTestChan ? TEST_CODE : addrShift;
  assign sdo        = outShift[DATA_W-1];

  assert_hold_R3: assert property (@(posedge clk) disable iff (!rstN)
    (!ctl.takeResult && !ctl.takeTest) |=> $stable(resultReg));

  assert_capture_R8: assert property (@(posedge clk) disable iff (!rstN)
    ctl.takeResult |=> (resultReg == $past(convResult)));

  assert_test_value_R9: assert property (@(posedge clk) disable iff (!rstN)
    ctl.takeTest |=> (resultReg == TEST_VALUE));

endmodule

// File: rtl/adcSerialSlave.sv
module adcSerialSlave
  import adcSerialPkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int ADDR_W      = 4,
  parameter int NUM_INPUTS  = 11,
  parameter int SYNC_STAGES = 2,
  parameter int CS_VALID    = 3,
  parameter int TEST_LAT    = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              csN,
  input  logic              sclk,
  input  logic              din,
  input  logic [DATA_W-1:0] convResult,
  input  logic              convDone,
  output logic              sdo,
  output logic              sdoOe,
  output logic              eoc,
  output logic              convStart,
  output logic              convAbort,
  output logic [ADDR_W-1:0] convChan,
  output logic              convSample
);
  logic    sclkS, csNS, dinS;
  logic    isTestChan;
  dpCtrl_t ctl;

  adcSyncChain #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b0)) uSyncSclk (
    .clk(clk), .rstN(rstN), .asyncIn(sclk), .syncOut(sclkS));
  adcSyncChain #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) uSyncCs (
    .clk(clk), .rstN(rstN), .asyncIn(csN), .syncOut(csNS));
  adcSyncChain #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b0)) uSyncDin (
    .clk(clk), .rstN(rstN), .asyncIn(din), .syncOut(dinS));

  adcSerialCtrl #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .CS_VALID(CS_VALID), .TEST_LAT(TEST_LAT)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .sclkS(sclkS), .csNS(csNS),
    .isTestChan(isTestChan), .convDone(convDone), .ctl(ctl),
    .convStart(convStart), .convAbort(convAbort), .eoc(eoc),
    .sdoOe(sdoOe), .convSample(convSample));

  adcSerialDatapath #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .NUM_INPUTS(NUM_INPUTS)
  ) uDp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .dinS(dinS),
    .convResult(convResult), .sdo(sdo), .isTestChan(isTestChan),
    .convChan(convChan));

endmodule

// File: tb/adcSerialSlave_test.sv
module adcSerialSlave_test;
  localparam int HALF = 4;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       csN = 1'b1;
  logic       sclk = 1'b0;
  logic       din = 1'b0;
  logic [7:0] convResult = 8'h00;
  logic       convDone = 1'b0;
  logic       sdo, sdoOe, eoc, convStart, convAbort, convSample;
  logic [3:0] convChan;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  int   convDelay = 20;
  int   startCount = 0;
  int   abortCount = 0;
  logic [3:0] lastChan = 4'h0;
  bit   pending = 0;
  int   remain = 0;

  logic [7:0] expQ[$];
  logic [7:0] gotQ[$];
  event       gotEv;

  adcSerialSlave uut (
    .clk(clk), .rstN(rstN), .csN(csN), .sclk(sclk), .din(din),
    .convResult(convResult), .convDone(convDone), .sdo(sdo), .sdoOe(sdoOe),
    .eoc(eoc), .convStart(convStart), .convAbort(convAbort),
    .convChan(convChan), .convSample(convSample));

  always #5 clk = ~clk;

  function automatic logic [7:0] resFor(input logic [3:0] c);
    return {c, ~c} ^ 8'h5A;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  // converter model
  initial begin
    forever begin
      @(negedge clk);
      convDone = 1'b0;
      if (convAbort) begin
        pending = 0;
        abortCount++;
      end
      if (convStart) begin
        startCount++;
        lastChan   = convChan;
        convResult = resFor(convChan);
        pending    = 1;
        remain     = convDelay;
      end else if (pending) begin
        if (remain == 0) begin
          convDone = 1'b1;
          pending  = 0;
        end else begin
          remain--;
        end
      end
    end
  end

  // scoreboard monitor
  initial begin
    forever begin
      @(gotEv);
      while (gotQ.size() > 0 && expQ.size() > 0) begin
        logic [7:0] g, e;
        g = gotQ.pop_front();
        e = expQ.pop_front();
        check(g == e, "R4 R8 result byte", g, e);
      end
    end
  end

  task automatic selLow();
    csN = 1'b0;
    cycles(10);
  endtask

  task automatic selHigh();
    csN = 1'b1;
    cycles(6);
  endtask

  task automatic frame(input logic [3:0] addr, input logic [3:0] junk,
                       input logic [7:0] expByte);
    logic [7:0] got;
    expQ.push_back(expByte);
    for (int i = 0; i < 8; i++) begin
      din = (i < 4) ? addr[3-i] : junk[7-i];
      cycles(HALF);
      sclk = 1'b1;
      cycles(HALF);
      got[7-i] = sdo;
      check(sdoOe == 1'b1, "R1 output enabled in frame", sdoOe, 1);
      check(convSample == (i >= 4), "R10 sampling window", convSample, (i >= 4));
      sclk = 1'b0;
    end
    cycles(8);
    gotQ.push_back(got);
    -> gotEv;
  endtask

  task automatic waitEoc(input string req);
    int n = 0;
    while (!eoc && n < 2000) begin
      cycles(1);
      n++;
    end
    check(eoc == 1'b1, req, eoc, 1);
  endtask

  initial begin
    int s0;
    cycles(4);
    rstN = 1'b1;
    cycles(3);
    // R11 reset state
    check(eoc == 1'b1, "R11 eoc after reset", eoc, 1);
    check(sdoOe == 1'b0, "R11 output disabled", sdoOe, 0);
    check(convStart == 1'b0, "R11 no start", convStart, 0);
    check(convAbort == 1'b0, "R11 no abort", convAbort, 0);

    // first transfer returns reset result, channel 3
    selLow();
    frame(4'h3, 4'hF, 8'h00);
    check(eoc == 1'b0, "R6 eoc low after eighth clock", eoc, 0);
    check(sdoOe == 1'b0, "R7 output off with select low", sdoOe, 0);
    check(startCount == 1, "R6 one start pulse", startCount, 1);
    check(lastChan == 4'h3, "R5 channel captured", lastChan, 3);
    waitEoc("R8 eoc rises on done");

    // channel 0xA, trailing din bits must not disturb the address
    frame(4'hA, 4'h5, resFor(4'h3));
    check(lastChan == 4'hA, "R5 trailing bits ignored", lastChan, 4'hA);
    waitEoc("R8 eoc rises");

    // self-test code 0xB, no external start
    s0 = startCount;
    frame(4'hB, 4'h0, resFor(4'hA));
    check(startCount == s0, "R9 no start for test code", startCount, s0);
    waitEoc("R9 eoc after self-test");

    // folded test code 0xE returns mid-scale
    frame(4'hE, 4'h0, 8'h80);
    check(startCount == s0, "R9 no start for folded code", startCount, s0);
    waitEoc("R9 eoc after folded test");

    // long conversion with extra clocks during lockout
    convDelay = 100;
    frame(4'h5, 4'h0, 8'h80);
    for (int k = 0; k < 3; k++) begin
      din = 1'b1;
      cycles(HALF);
      sclk = 1'b1;
      cycles(HALF);
      check(sdoOe == 1'b0, "R7 output off during lockout", sdoOe, 0);
      sclk = 1'b0;
    end
    check(eoc == 1'b0, "R7 still converting", eoc, 0);
    waitEoc("R8 eoc after long conversion");
    convDelay = 20;
    frame(4'h1, 4'h0, resFor(4'h5));

    // select glitch during conversion must not abort
    selHigh();
    check(sdoOe == 1'b0, "R1 output off with select high", sdoOe, 0);
    csN = 1'b0;
    cycles(1);
    csN = 1'b1;
    cycles(6);
    check(abortCount == 0, "R2 glitch ignored", abortCount, 0);
    waitEoc("R2 conversion completes after glitch");

    // abort by valid reset during conversion
    selLow();
    convDelay = 300;
    frame(4'h2, 4'h0, resFor(4'h1));
    selHigh();
    selLow();
    check(abortCount == 1, "R3 abort pulse", abortCount, 1);
    check(eoc == 1'b1, "R3 eoc high after abort", eoc, 1);
    check(sdoOe == 1'b1, "R1 output enabled after valid select", sdoOe, 1);
    convDelay = 20;
    frame(4'h4, 4'h0, resFor(4'h1));
    waitEoc("R8 eoc after conversion");

    // partial frame then interface reset realigns
    for (int k = 0; k < 3; k++) begin
      din = 1'b0;
      cycles(HALF);
      sclk = 1'b1;
      cycles(HALF);
      sclk = 1'b0;
    end
    cycles(4);
    selHigh();
    selLow();
    frame(4'h7, 4'h0, resFor(4'h4));
    check(lastChan == 4'h7, "R2 realigned after reset", lastChan, 7);
    waitEoc("R8 final eoc");
    cycles(4);
    check(expQ.size() == 0, "R4 scoreboard drained", expQ.size(), 0);

    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=0x0 expected=0x1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule